// File: doc/BRIEF.md
# Thread Block Dispatcher

This block places incoming thread blocks onto a set of parallel execution clusters. An upstream launch source presents one block descriptor at a time, made of a block number and a grid number, on a valid/ready handshake. When at least one cluster has a free residency slot, the descriptor is accepted in that cycle. A target cluster is chosen in round-robin order, and a registered assignment record is issued on the following cycle. A block stays on the cluster it was given until that cluster reports it finished, and it is never moved. Blocks from different grids can share a cluster.

Each cluster holds at most `SLOTS` resident blocks at once. The dispatcher keeps one occupancy counter per cluster. A counter goes up on an assignment and down on a completion report that names the cluster. When every cluster is at its limit, ready drops. The upstream source then holds its descriptors until a completion frees a slot. A per-cluster busy vector and a global idle flag show the state of the whole set.

Top module: `block_dispatcher`

## Requirements
- R1: After reset every cluster is empty, `in_ready` is high, `asg_valid` is low, `cluster_busy` is all zeros, and `all_idle` is high whenever `in_valid` is low.
- R2: A descriptor is accepted in a cycle where `in_valid` and `in_ready` are both high. In the next cycle `asg_valid` is high and carries that descriptor's block and grid numbers. `asg_valid` is low in every other cycle.
- R3: No cluster ever holds more than `SLOTS` resident blocks (8 by default), and a cluster at its limit is never chosen.
- R4: The search for a target starts at the cluster after the one last assigned (index 0 after reset). It moves upward, wrapping from `N_CLUSTERS-1` to 0, and skips full clusters. The first cluster with a free slot is chosen.
- R5: `in_ready` is low exactly when all clusters are at their limit. While it is low, no descriptor is accepted and no assignment is issued.
- R6: A completion (`cmp_valid` high, `cmp_cluster` = index) removes one block from that cluster. The freed slot can be used from the next cycle on.
- R7: If a completion and an assignment hit the same cluster in the same cycle, that cluster's occupancy is unchanged.
- R8: A completion that names a cluster with no resident blocks is ignored. The cluster stays empty and keeps its full capacity.
- R9: `cluster_busy[i]` is high exactly when cluster i holds at least one block. `all_idle` is high exactly when no cluster is busy and `in_valid` is low.
- R10: The grid number has no effect on placement. Blocks of any mix of grids are placed by R4 alone and are reported with their own grid number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Some cluster has a free slot |
| in_block_id | input | BLOCK_W | Block number of offered descriptor |
| in_grid_id | input | GRID_W | Grid number of offered descriptor |
| asg_valid | output | 1 | Assignment record valid (one cycle) |
| asg_cluster | output | CL_W | Cluster the block was placed on |
| asg_block_id | output | BLOCK_W | Block number of the assignment |
| asg_grid_id | output | GRID_W | Grid number of the assignment |
| cmp_valid | input | 1 | A cluster finished one block |
| cmp_cluster | input | CL_W | Index of the finishing cluster |
| cluster_busy | output | N_CLUSTERS | Per-cluster nonzero-occupancy flags |
| all_idle | output | 1 | All clusters empty and no descriptor offered |

## Verification
The hardest state to reach is a fully saturated set where exactly one slot then frees. That is the only case in which the skip-over-full search must jump across several clusters. The bench reaches it directly by offering descriptors back to back with no completions until ready drops. It holds the offer while full, then completes a single block on one chosen cluster and checks that the next block lands there. Long random runs with varied offer and completion rates then revisit near-full states. Those runs also produce same-cycle completion and assignment on one cluster, and completions aimed at empty clusters.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  // Advance a cluster index by one with wraparound.
  function automatic int next_index(input int idx, input int count);
    int r;
    r = idx + 1;
    if (r >= count) r = 0;
    return r;
  endfunction

  // Add an offset to a cluster index with wraparound (offset < count).
  function automatic int offset_index(input int base, input int ofs, input int count);
    int r;
    r = base + ofs;
    if (r >= count) r = r - count;
    return r;
  endfunction

endpackage

// File: rtl/occ_slot_counter.sv
module occ_slot_counter #(
  parameter int SLOTS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec_req,
  output logic has_room,
  output logic busy
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SLOTS);

  logic [CNT_W-1:0] count_q, count_d;
  logic             dec;
  logic             cnt_en;

  always_comb begin
    dec    = dec_req && (count_q != '0);
    cnt_en = inc ^ dec;
    count_d = count_q;
    if (inc && !dec)      count_d = count_q + 1'b1;
    else if (dec && !inc) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign has_room = (count_q < LIMIT);
  assign busy     = (count_q != '0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LIMIT);

  assert_no_inc_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == LIMIT) |-> !inc || dec_req);

  assert_empty_completion_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !inc && count_q == '0) |=> (count_q == '0));

  assert_same_cycle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec_req && count_q != '0) |=> $stable(count_q));

endmodule

// File: rtl/rr_slot_picker.sv
module rr_slot_picker
  import dispatch_pkg::*;
#(
  parameter int N_CLUSTERS = 4,
  parameter int CL_W       = 2
) (
  input  logic [N_CLUSTERS-1:0] free,
  input  logic [CL_W-1:0]       start,
  output logic                  found,
  output logic [CL_W-1:0]       pick
);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N_CLUSTERS; k++) begin
      int idx;
      idx = offset_index(int'(start), k, N_CLUSTERS);
      if (!found && free[idx]) begin
        found = 1'b1;
        pick  = CL_W'(idx);
      end
    end
  end

  always_comb begin
    if (found) assert_pick_has_room_R3: assert (free[pick]);
    if (free[start]) assert_pick_start_first_R4: assert (!found || pick == start);
  end

endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
  import dispatch_pkg::*;
#(
  parameter int N_CLUSTERS = 4,
  parameter int SLOTS      = 8,
  parameter int BLOCK_W    = 16,
  parameter int GRID_W     = 4,
  parameter int CL_W       = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BLOCK_W-1:0]    in_block_id,
  input  logic [GRID_W-1:0]     in_grid_id,
  output logic                  asg_valid,
  output logic [CL_W-1:0]       asg_cluster,
  output logic [BLOCK_W-1:0]    asg_block_id,
  output logic [GRID_W-1:0]     asg_grid_id,
  input  logic                  cmp_valid,
  input  logic [CL_W-1:0]       cmp_cluster,
  output logic [N_CLUSTERS-1:0] cluster_busy,
  output logic                  all_idle
);

  logic [N_CLUSTERS-1:0] free;
  logic                  found;
  logic [CL_W-1:0]       pick;
  logic                  accept;
  logic [CL_W-1:0]       ptr_q, ptr_d;

  // Round-robin choice among clusters with room
  rr_slot_picker #(
    .N_CLUSTERS (N_CLUSTERS),
    .CL_W       (CL_W)
  ) u_picker (
    .free  (free),
    .start (ptr_q),
    .found (found),
    .pick  (pick)
  );

  assign in_ready = found;
  assign accept   = in_valid && found;

  // One occupancy counter per cluster
  for (genvar i = 0; i < N_CLUSTERS; i++) begin : g_cluster
    logic inc_i, dec_i;
    assign inc_i = accept && (pick == CL_W'(i));
    assign dec_i = cmp_valid && (cmp_cluster == CL_W'(i));
    occ_slot_counter #(
      .SLOTS (SLOTS)
    ) u_occ (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc_i),
      .dec_req  (dec_i),
      .has_room (free[i]),
      .busy     (cluster_busy[i])
    );
  end

  // Pointer next state: one past the cluster just chosen
  always_comb begin
    ptr_d = ptr_q;
    if (accept) ptr_d = CL_W'(next_index(int'(pick), N_CLUSTERS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (accept) ptr_q <= ptr_d;
  end

  // Assignment record registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) asg_valid <= 1'b0;
    else        asg_valid <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asg_cluster  <= '0;
      asg_block_id <= '0;
      asg_grid_id  <= '0;
    end else if (accept) begin
      asg_cluster  <= pick;
      asg_block_id <= in_block_id;
      asg_grid_id  <= in_grid_id;
    end
  end

  assign all_idle = ~(|cluster_busy) && !in_valid;

  assert_accept_gives_record_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> asg_valid && asg_block_id == $past(in_block_id)
                               && asg_grid_id == $past(in_grid_id));

  assert_record_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> $past(in_valid && in_ready));

  assert_no_dispatch_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !asg_valid);

  assert_record_lands_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> cluster_busy[asg_cluster]);

endmodule

// File: tb/block_dispatcher_tb.sv
`timescale 1ns/1ps
module block_dispatcher_tb;
  localparam int NC = 4;
  localparam int SL = 8;
  localparam int BW = 16;
  localparam int GW = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [BW-1:0] in_block_id = '0;
  logic [GW-1:0] in_grid_id = '0;
  logic asg_valid;
  logic [CW-1:0] asg_cluster;
  logic [BW-1:0] asg_block_id;
  logic [GW-1:0] asg_grid_id;
  logic cmp_valid = 1'b0;
  logic [CW-1:0] cmp_cluster = '0;
  logic [NC-1:0] cluster_busy;
  logic all_idle;

  always #2.5 clk = ~clk;

  block_dispatcher #(.N_CLUSTERS(NC), .SLOTS(SL), .BLOCK_W(BW), .GRID_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block_id(in_block_id), .in_grid_id(in_grid_id), .asg_valid(asg_valid),
    .asg_cluster(asg_cluster), .asg_block_id(asg_block_id), .asg_grid_id(asg_grid_id),
    .cmp_valid(cmp_valid), .cmp_cluster(cmp_cluster), .cluster_busy(cluster_busy),
    .all_idle(all_idle));

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference model state
  int cnt_m[NC];
  int ptr_m;
  bit exp_av;
  int exp_cl;
  int exp_bid;
  int exp_gid;

  task automatic chk(input string tag, input int act, input int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit model_ready();
    for (int i = 0; i < NC; i++) if (cnt_m[i] < SL) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int model_pick();
    for (int k = 0; k < NC; k++) begin
      int idx;
      idx = (ptr_m + k) % NC;
      if (cnt_m[idx] < SL) return idx;
    end
    return -1;
  endfunction

  function automatic bit model_idle(input bit v);
    for (int i = 0; i < NC; i++) if (cnt_m[i] != 0) return 1'b0;
    return !v;
  endfunction

  // One clock: check outputs, drive inputs, advance the model.
  task automatic step(input bit v, input int bid, input int gid,
                      input bit cv, input int cc, input string note);
    bit rdy;
    int g;
    @(negedge clk);
    chk({"R2 asg_valid ", note}, int'(asg_valid), int'(exp_av));
    if (exp_av) begin
      chk({"R4 asg_cluster ", note}, int'(asg_cluster), exp_cl);
      chk({"R2 asg_block_id ", note}, int'(asg_block_id), exp_bid);
      chk({"R10 asg_grid_id ", note}, int'(asg_grid_id), exp_gid);
    end
    rdy = model_ready();
    chk({"R5 R3 R6 in_ready ", note}, int'(in_ready), int'(rdy));
    for (int i = 0; i < NC; i++)
      chk({"R9 cluster_busy ", note}, int'(cluster_busy[i]), int'(cnt_m[i] != 0));
    in_valid = v;
    in_block_id = BW'(bid);
    in_grid_id = GW'(gid);
    cmp_valid = cv;
    cmp_cluster = CW'(cc);
    #1;
    chk({"R9 all_idle ", note}, int'(all_idle), int'(model_idle(v)));
    exp_av = v && rdy;
    g = -1;
    if (exp_av) begin
      g = model_pick();
      exp_cl = g;
      exp_bid = bid;
      exp_gid = gid;
    end
    // R7/R8: decrement only a nonzero count, judged on the pre-edge value
    if (cv && cnt_m[cc] > 0) cnt_m[cc]--;
    if (g >= 0) begin
      cnt_m[g]++;
      ptr_m = (g + 1) % NC;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int bid;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < NC; i++) cnt_m[i] = 0;
    ptr_m = 0;
    exp_av = 1'b0;
    exp_cl = 0; exp_bid = 0; exp_gid = 0;
    bid = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    step(1'b0, 0, 0, 1'b0, 0, "R1 reset");
    step(1'b0, 0, 0, 1'b0, 0, "R1 reset");

    // R8: completion to an empty cluster is ignored
    step(1'b0, 0, 0, 1'b1, 1, "R8 empty completion");
    step(1'b0, 0, 0, 1'b0, 0, "R8 after");

    // R3/R4/R5: fill every slot back to back, with mixed grids (R10)
    for (int k = 0; k < NC * SL; k++) begin
      step(1'b1, bid, k % 16, 1'b0, 0, "R3 R10 fill");
      bid++;
    end
    // R5: held offers while full produce nothing
    for (int k = 0; k < 3; k++) step(1'b1, bid, 7, 1'b0, 0, "R5 full hold");
    // R6/R4: free one slot on cluster 2; the next block must skip to it
    step(1'b1, bid, 7, 1'b1, 2, "R6 free one");
    step(1'b1, bid, 7, 1'b0, 0, "R4 skip full");
    bid++;
    step(1'b0, 0, 0, 1'b0, 0, "R5 full again");
    step(1'b0, 0, 0, 1'b0, 0, "R5 full again");

    // R7: completion and assignment on the same cluster in one cycle
    step(1'b0, 0, 0, 1'b1, 3, "R6 free c3");
    step(1'b1, bid, 3, 1'b1, 3, "R7 same cycle");
    bid++;
    step(1'b0, 0, 0, 1'b0, 0, "R7 after");

    // Drain everything, then observe idle
    for (int k = 0; k < SL + 2; k++)
      for (int c = 0; c < NC; c++) step(1'b0, 0, 0, 1'b1, c, "R6 drain");
    step(1'b0, 0, 0, 1'b0, 0, "R9 idle");

    // Random phase: varying offer and completion density
    for (int k = 0; k < 6000; k++) begin
      bit v, cv;
      int pv, pc;
      pv = (k < 3000) ? 80 : 40;
      pc = (k < 3000) ? 30 : 60;
      v  = ($urandom % 100) < pv;
      cv = ($urandom % 100) < pc;
      step(v, bid, int'($urandom % 16), cv, int'($urandom % NC), "R4 R7 R10 random");
      if (v) bid++;
    end
    step(1'b0, 0, 0, 1'b0, 0, "final");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule